// File: doc/BRIEF.md
# RTC Shadow Register Update Handshake

This block sits on the register side of a real-time clock. The host stages time and alarm values in a bank of 8-bit shadow registers. It then sets request bits in an update-control register to move those values to or from the live timekeeping logic. There are three separate requests: commit the staged time, refresh the shadow time from the live counters, and commit the staged alarm. Each request starts a transfer that runs for a fixed number of reference-clock cycles. The duration comes from a long or a short setting. When the transfer ends, the block clears the request bit by itself and pulses a one-cycle strobe toward the counter or alarm storage.

A time commit also needs a time-enable qualifier, so an alarm-only update cannot overwrite the running time. The control register also holds a two-bit staged mode field. That field reaches the live domain only when an alarm update completes. Two build options change the handshake. In the first, the alarm request bit is held after completion until the host writes it to zero. In the second, the read-time path is removed.

The register port decodes a 5-bit address. Addresses 0 to 7 are the time shadow group and 8 to 15 are the alarm shadow group, each ordered seconds, minutes, hours, weekday, date, month, year-low, year-high. Address 16 is the control register.

Top module: `rtc_shadow_sync`

## Requirements
- R1: After reset the control register reads 0x00, every shadow byte reads 0, `busy`, `time_load` and `alarm_load` are low, and `live_mode` is 0.
- R2: A write to a shadow address stores the byte; reading it back returns it, and `time_image`/`alarm_image` present byte i on bits [8i+7:8i]. Shadow addresses at or above REG_COUNT in either group read 0.
- R3: Writing the control register (address 16) with any of bit0 (time commit), bit1 (time refresh) or bit2 (alarm commit) set starts a transfer. The written bits read back at once together with bit7 (busy) set. They stay so for exactly D cycles, then bit7 and the request bits read 0. D is LONG_TICKS when bit4 (fast) is 0 and SHORT_TICKS when bit4 is 1.
- R4: `time_load` pulses for one cycle, in the cycle `busy` falls, only when the finished transfer had both bit0 and bit3 (time enable) set; `time_image` then carries the staged time.
- R5: A finished time-refresh transfer copies `live_time` into the time shadow group.
- R6: `alarm_load` pulses for one cycle when an alarm-commit transfer finishes. At that same edge `live_mode` takes the staged mode field (control bits 6:5); at no other time does `live_mode` change.
- R7: A control-register write that arrives while a transfer is running is ignored entirely. The register keeps its contents and the running transfer completes as originally requested.
- R8: With ALARM_HOLD=1, the alarm-commit bit still reads 1 after its transfer completes, and it is cleared only by a host control write with bit2 at 0.
- R9: With RD_PATH_EN=0, bit1 is never stored, reads 0 and starts no transfer, and the time shadow is never overwritten from `live_time`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| live_time | input | REG_COUNT*8 | Current live counter values, byte per field |
| time_image | output | REG_COUNT*8 | Time shadow contents toward the counters |
| alarm_image | output | REG_COUNT*8 | Alarm shadow contents toward alarm storage |
| time_load | output | 1 | One-cycle time commit strobe |
| alarm_load | output | 1 | One-cycle alarm commit strobe |
| busy | output | 1 | Transfer in progress |
| live_mode | output | 2 | Mode field applied by the last alarm commit |

## Verification
A control write sampled at one edge makes the request and busy bits readable in the cycle after it. Those bits stay set through D-1 further cycles. Busy falls at the D-th edge after the write, and the strobes, the refreshed shadow and the new `live_mode` appear in that same cycle. The bench drives and samples on the falling edge. It counts exactly D falling edges from the write before it checks completion, and it checks at every intermediate edge that nothing completes early. Reads are combinational and are sampled 1 ns after the address changes. A second instance built with a held alarm bit and no read path covers the build options.

// File: rtl/rtc_shadow_sync.sv
module rtc_shadow_sync #(
  parameter int REG_COUNT   = 8,
  parameter int LONG_TICKS  = 7320,
  parameter int SHORT_TICKS = 450,
  parameter bit ALARM_HOLD  = 1'b0,
  parameter bit RD_PATH_EN  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [4:0]             addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [REG_COUNT*8-1:0] live_time,
  output logic [REG_COUNT*8-1:0] time_image,
  output logic [REG_COUNT*8-1:0] alarm_image,
  output logic                   time_load,
  output logic                   alarm_load,
  output logic                   busy,
  output logic [1:0]             live_mode
);
  localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [4:0] CTL_ADDR = 5'd16;

  logic [7:0] tsh [REG_COUNT];
  logic [7:0] ash [REG_COUNT];

  logic             req_wt, req_rt, req_al, time_en, fast;
  logic [1:0]       mode_stage;
  logic             busy_q, tl_q, al_q;
  logic [CNT_W-1:0] cnt;

  logic [2:0] idx;
  logic       ctl_wr, accept, rd_bit, start, done;

  assign idx    = addr[2:0];
  assign ctl_wr = wr_en && (addr == CTL_ADDR);
  assign accept = ctl_wr && !busy_q;
  assign rd_bit = RD_PATH_EN && wdata[1];
  assign start  = accept && (wdata[0] || rd_bit || wdata[2]);
  assign done   = busy_q && (cnt == CNT_W'(1));

  assign busy       = busy_q;
  assign time_load  = tl_q;
  assign alarm_load = al_q;

  for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_byte
    assign time_image[gi*8 +: 8]  = tsh[gi];
    assign alarm_image[gi*8 +: 8] = ash[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tsh[gi] <= '0;
        ash[gi] <= '0;
      end else begin
        if (done && req_rt)
          tsh[gi] <= live_time[gi*8 +: 8];
        else if (wr_en && addr == 5'(gi))
          tsh[gi] <= wdata;
        if (wr_en && addr == 5'(8 + gi))
          ash[gi] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTL_ADDR)
      rdata = {busy_q, mode_stage, fast, time_en, req_al, req_rt, req_wt};
    else if (addr[4:3] == 2'b00 && int'(idx) < REG_COUNT)
      rdata = tsh[idx];
    else if (addr[4:3] == 2'b01 && int'(idx) < REG_COUNT)
      rdata = ash[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_wt     <= 1'b0;
      req_rt     <= 1'b0;
      req_al     <= 1'b0;
      time_en    <= 1'b0;
      fast       <= 1'b0;
      mode_stage <= '0;
      live_mode  <= '0;
      busy_q     <= 1'b0;
      cnt        <= '0;
      tl_q       <= 1'b0;
      al_q       <= 1'b0;
    end else begin
      tl_q <= done && req_wt && time_en;
      al_q <= done && req_al;
      if (accept) begin
        req_wt     <= wdata[0];
        req_rt     <= rd_bit;
        req_al     <= wdata[2];
        time_en    <= wdata[3];
        fast       <= wdata[4];
        mode_stage <= wdata[6:5];
        if (start) begin
          busy_q <= 1'b1;
          cnt    <= wdata[4] ? CNT_W'(SHORT_TICKS) : CNT_W'(LONG_TICKS);
        end
      end else if (done) begin
        busy_q <= 1'b0;
        cnt    <= '0;
        req_wt <= 1'b0;
        req_rt <= 1'b0;
        if (!ALARM_HOLD) req_al <= 1'b0;
        if (req_al) live_mode <= mode_stage;
      end else if (busy_q) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rtc_shadow_sync_chk.sv
module rtc_shadow_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [4:0] addr,
  input logic       busy,
  input logic       time_load,
  input logic       alarm_load,
  input logic [1:0] live_mode
);
  AST_BUSY_FROM_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && addr == 5'd16)); // R3
  AST_TIME_STROBE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |-> $fell(busy)); // R4
  AST_TIME_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |=> !time_load); // R4
  AST_ALARM_STROBE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_load |-> $fell(busy)); // R6
  AST_MODE_ONLY_ON_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_load |-> $stable(live_mode)); // R6
endmodule

bind rtc_shadow_sync rtc_shadow_sync_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .busy(busy),
  .time_load(time_load), .alarm_load(alarm_load), .live_mode(live_mode)
);

// File: tb/rtc_shadow_sync_tb.sv
module rtc_shadow_sync_tb;
  localparam int LA = 20, SA = 3, LB = 5, SB = 2;
  localparam logic [4:0] CTL = 5'd16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, wr_a, wr_b;
  logic [4:0]  addr;
  logic [7:0]  wdata, rdata_a, rdata_b;
  logic [63:0] live_a, timg_a, aimg_a;
  logic [55:0] live_b, timg_b, aimg_b;
  logic        tl_a, al_a, busy_a, tl_b, al_b, busy_b;
  logic [1:0]  mode_a, mode_b;

  rtc_shadow_sync #(.REG_COUNT(8), .LONG_TICKS(LA), .SHORT_TICKS(SA)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .addr(addr), .wdata(wdata), .rdata(rdata_a),
    .live_time(live_a), .time_image(timg_a), .alarm_image(aimg_a),
    .time_load(tl_a), .alarm_load(al_a), .busy(busy_a), .live_mode(mode_a));

  rtc_shadow_sync #(.REG_COUNT(7), .LONG_TICKS(LB), .SHORT_TICKS(SB),
                    .ALARM_HOLD(1'b1), .RD_PATH_EN(1'b0)) u_alt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .addr(addr), .wdata(wdata), .rdata(rdata_b),
    .live_time(live_b), .time_image(timg_b), .alarm_image(aimg_b),
    .time_load(tl_b), .alarm_load(al_b), .busy(busy_b), .live_mode(mode_b));

  int n_cmp = 0, n_bad = 0;
  logic [7:0] tm [8];
  logic [7:0] am [8];
  logic [1:0] mode_m;
  logic [7:0] v;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input logic [7:0] b [8]);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = b[i];
    return r;
  endfunction

  task automatic wr(input bit which, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (which) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input bit which, input logic [4:0] a, output logic [7:0] d);
    addr = a;
    #1 d = which ? rdata_b : rdata_a;
  endtask

  task automatic run_transfer(input logic [7:0] c);
    int d;
    logic [7:0] r;
    d = c[4] ? SA : LA;
    live_a = {$urandom, $urandom};
    wr(0, CTL, c);
    rd(0, CTL, r);
    chk("R3 request and busy readable", r, {1'b1, c[6:0]});
    for (int k = 1; k < d; k++) begin
      @(negedge clk);
      chk("R3 busy held", busy_a, 1'b1);
      chk("R4 no early time strobe", tl_a, 1'b0);
    end
    @(negedge clk);
    chk("R3 busy clears after D", busy_a, 1'b0);
    chk("R4 time strobe qualified", tl_a, c[0] & c[3]);
    chk("R6 alarm strobe", al_a, c[2]);
    if (c[2]) mode_m = c[6:5];
    chk("R6 live mode", mode_a, mode_m);
    if (c[1]) for (int i = 0; i < 8; i++) tm[i] = live_a[i*8 +: 8];
    chk("R5 R4 time image", timg_a, pack(tm));
    rd(0, CTL, r);
    chk("R3 request bits auto-cleared", r, {1'b0, c[6:3], 3'b000});
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [4:0] a;
    logic [7:0] c;
    rst_n = 1'b0; wr_a = 1'b0; wr_b = 1'b0; addr = '0; wdata = '0;
    live_a = '0; live_b = '0; mode_m = '0;
    for (int i = 0; i < 8; i++) begin tm[i] = '0; am[i] = '0; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, CTL, v); chk("R1 control reset", v, 8'h00);
    rd(0, 5'd3, v); chk("R1 shadow reset", v, 8'h00);
    chk("R1 strobes and busy low", {tl_a, al_a, busy_a}, 3'b000);
    chk("R1 live mode reset", mode_a, 2'd0);
    chk("R1 image reset", timg_a, 64'h0);

    for (int n = 0; n < 24; n++) begin
      a = 5'($urandom % 16);
      c = 8'($urandom);
      wr(0, a, c);
      if (a[3]) am[a[2:0]] = c; else tm[a[2:0]] = c;
    end
    for (int i = 0; i < 16; i++) begin
      rd(0, 5'(i), v);
      chk("R2 shadow readback", v, i < 8 ? tm[i] : am[i-8]);
    end
    chk("R2 time image layout", timg_a, pack(tm));
    chk("R2 alarm image layout", aimg_a, pack(am));
    wr(1, 5'd7, 8'h3C);
    rd(1, 5'd7, v); chk("R2 absent byte reads 0", v, 8'h00);

    run_transfer(8'h19);
    run_transfer(8'h11);
    run_transfer(8'h09);
    run_transfer(8'h12);
    run_transfer(8'h54);

    wr(0, CTL, 8'h09);
    repeat (4) @(negedge clk);
    wr(0, CTL, 8'h64);
    rd(0, CTL, v); chk("R7 write during busy ignored", v, 8'h89);
    repeat (14) @(negedge clk);
    chk("R7 original transfer completes", {busy_a, tl_a, al_a}, 3'b010);
    chk("R7 mode untouched", mode_a, mode_m);

    for (int n = 0; n < 6; n++) begin
      c = 8'($urandom) & 8'h7F;
      if (c[2:0] == 3'b000) c[0] = 1'b1;
      run_transfer(c);
    end

    wr(1, CTL, 8'h34);
    @(negedge clk);
    @(negedge clk);
    chk("R8 alarm strobe on held build", {busy_b, al_b}, 2'b01);
    chk("R6 live mode on held build", mode_b, 2'd1);
    rd(1, CTL, v); chk("R8 alarm bit held", v, 8'h34);
    repeat (3) @(negedge clk);
    rd(1, CTL, v); chk("R8 alarm bit still held", v, 8'h34);
    wr(1, CTL, 8'h10);
    rd(1, CTL, v); chk("R8 host write clears alarm bit", v, 8'h10);

    wr(1, 5'd0, 8'hA5);
    live_b = {$urandom, $urandom};
    wr(1, CTL, 8'h12);
    rd(1, CTL, v); chk("R9 read request dropped", v, 8'h10);
    chk("R9 no transfer started", busy_b, 1'b0);
    repeat (LB + 2) @(negedge clk);
    rd(1, 5'd0, v); chk("R9 shadow not refreshed", v, 8'hA5);

    finish_run();
  end
endmodule